// File: doc/BRIEF.md
# Freezer Halt Controller

This block sits on an expansion cartridge and turns a press of the freeze button into an ordered takeover of the host CPU. It pulls the bus-available line low to stop the processor. It waits until the processor has completed a run of read cycles, so that any write that was in progress has reached memory. It then switches the host memory map to console mode, with GAME low and EXROM high, so that cartridge ROM covers the top 8 kB including the interrupt vectors. After that it pulls NMI low and finally releases bus-available. The CPU finishes its current instruction and enters the cartridge's interrupt handler.

All board-side inputs are asynchronous: the button, the CPU phase clock, R/W and the sensed level of the shared NMI line. They pass through synchronisers. The button is also debounced. Each rising edge of the phase clock marks one completed CPU bus cycle. The sequence stays active, and further presses are ignored, until the cartridge software pulses the release strobe. The strobe puts the map back to normal and lets NMI go high again. A freeze is refused if the NMI line is already held low, because an edge-triggered interrupt would never be seen.

Top module: `frz_halt_ctrl`

## Requirements
- R1: During and after reset, `ba_n_o`, `game_n_o`, `exrom_n_o` and `nmi_n_o` are all high (1), meaning no line is asserted.
- R2: A button level passes a `SYNC_STAGES`-flop synchroniser and must stay unchanged for `DEB_CYCLES` consecutive clocks before it counts. A high pulse shorter than that never starts a freeze. A held press starts one.
- R3: An accepted press drives `ba_n_o` low first, while GAME and NMI stay high. The BA low interval is counted in completed CPU cycles, where a cycle completes on a rising edge of `cpu_phi_i`. A cycle with `cpu_rw_i` = 0 (write) resets the count.
- R4: On the completion of the `SETTLE_TICKS`-th consecutive read cycle (`cpu_rw_i` = 1) while BA is low, `game_n_o` goes low with `exrom_n_o` high (console map). BA stays low and NMI stays high.
- R5: On the next completed CPU cycle, `nmi_n_o` goes low. BA and GAME stay low.
- R6: On the next completed CPU cycle, `ba_n_o` returns high. NMI and GAME stay low.
- R7: In that released state, a one-clock high on `rel_stb_i` raises `game_n_o` and `nmi_n_o` together on the next clock. A strobe in any other state has no effect.
- R8: Presses made while a sequence is active are ignored. A button still held after the release does not start a new freeze.
- R9: If `nmi_sense_n_i` is low when a press is accepted, the press is dropped and all outputs stay high.
- R10: `exrom_n_o` stays high at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, faster than the CPU phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frz_btn_i | input | 1 | Raw freeze button, high = pressed |
| cpu_phi_i | input | 1 | CPU phase clock; each rising edge ends one bus cycle |
| cpu_rw_i | input | 1 | CPU R/W, 1 = read, 0 = write |
| nmi_sense_n_i | input | 1 | Sensed level of the shared NMI line |
| rel_stb_i | input | 1 | Release strobe from cartridge software, synchronous to clk |
| ba_n_o | output | 1 | Bus-available, low halts the CPU |
| game_n_o | output | 1 | GAME map line, low selects console map |
| exrom_n_o | output | 1 | EXROM map line, held high |
| nmi_n_o | output | 1 | Interrupt request, low asserted |

## Verification
A phase-clock edge reaches the sequencer after the synchroniser and one edge-detect flop, so every cycle-driven output change is visible at most four clocks after the rising edge of `cpu_phi_i`. The bench samples six clocks after that edge, which is well before the next edge 16 clocks later. It compares against a reference sequencer that it steps on each edge. A button press takes about `SYNC_STAGES + DEB_CYCLES + 2` clocks to take effect. For that reason the bench presses only on a phase edge and applies the press to its reference at the start of the next CPU cycle. The release strobe acts on the following clock, so it is issued at the start of a cycle and its effect is checked at that cycle's sample point.

// File: rtl/frz_pkg.sv
package frz_pkg;

   typedef enum logic [2:0] {
      FRZ_IDLE = 3'd0,
      FRZ_HALT = 3'd1,
      FRZ_MAP  = 3'd2,
      FRZ_ARM  = 3'd3,
      FRZ_RUN  = 3'd4
   } frz_state_e;

   // Active-low host lines driven by the cartridge
   typedef struct packed {
      logic ba_n;
      logic game_n;
      logic exrom_n;
      logic nmi_n;
   } frz_lines_t;

   localparam frz_lines_t FRZ_LINES_IDLE = '{ba_n: 1'b1, game_n: 1'b1, exrom_n: 1'b1, nmi_n: 1'b1};

   function automatic frz_lines_t frz_decode(frz_state_e s);
      frz_lines_t l;
      l = FRZ_LINES_IDLE;
      unique case (s)
         FRZ_IDLE: l = FRZ_LINES_IDLE;
         FRZ_HALT: l.ba_n = 1'b0;
         FRZ_MAP: begin
            l.ba_n   = 1'b0;
            l.game_n = 1'b0;
         end
         FRZ_ARM: begin
            l.ba_n   = 1'b0;
            l.game_n = 1'b0;
            l.nmi_n  = 1'b0;
         end
         FRZ_RUN: begin
            l.game_n = 1'b0;
            l.nmi_n  = 1'b0;
         end
         default: l = FRZ_LINES_IDLE;
      endcase
      return l;
   endfunction

endpackage

// File: rtl/frz_sync.sv
module frz_sync #(
   parameter int             WIDTH   = 1,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/frz_debounce.sv
module frz_debounce #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic level_o,
   output logic rise_o
);

   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

   logic level_q;
   logic level_prev_q;

   if (CYCLES <= 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) level_q <= 1'b0;
         else        level_q <= raw_i;
      end
   end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            level_q <= 1'b0;
            cnt_q   <= '0;
         end else if (raw_i != level_q) begin
            if (cnt_q == LAST) begin
               level_q <= raw_i;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_prev_q <= 1'b0;
      else        level_prev_q <= level_q;
   end

   assign level_o = level_q;
   assign rise_o  = level_q & ~level_prev_q;

endmodule

// File: rtl/frz_cycle_tick.sv
module frz_cycle_tick (
   input  logic clk,
   input  logic rst_n,
   input  logic phi_i,
   input  logic rw_i,
   output logic tick_o,
   output logic tick_rd_o
);

   logic phi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phi_q <= 1'b0;
      else        phi_q <= phi_i;
   end

   // rising phase edge: the bus cycle just ended; rw_i still holds its type
   assign tick_o    = phi_i & ~phi_q;
   assign tick_rd_o = rw_i;

endmodule

// File: rtl/frz_seq.sv
module frz_seq
   import frz_pkg::*;
#(
   parameter int SETTLE_TICKS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       press_i,
   input  logic       nmi_high_i,
   input  logic       tick_i,
   input  logic       tick_rd_i,
   input  logic       release_i,
   output frz_lines_t lines_o
);

   localparam int            CW   = $clog2(SETTLE_TICKS + 1);
   localparam logic [CW-1:0] LAST = CW'(SETTLE_TICKS - 1);

   frz_state_e    st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         FRZ_IDLE: begin
            cnt_d = '0;
            if (press_i && nmi_high_i) st_d = FRZ_HALT;
         end
         FRZ_HALT: begin
            if (tick_i) begin
               if (!tick_rd_i)          cnt_d = '0;
               else if (cnt_q == LAST)  st_d  = FRZ_MAP;
               else                     cnt_d = cnt_q + 1'b1;
            end
         end
         FRZ_MAP: if (tick_i) st_d = FRZ_ARM;
         FRZ_ARM: if (tick_i) st_d = FRZ_RUN;
         FRZ_RUN: if (release_i) st_d = FRZ_IDLE;
         default: st_d = FRZ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= FRZ_IDLE;
         cnt_q   <= '0;
         lines_o <= FRZ_LINES_IDLE;
      end else begin
         st_q    <= st_d;
         cnt_q   <= cnt_d;
         lines_o <= frz_decode(st_d);
      end
   end

endmodule

// File: rtl/frz_halt_ctrl.sv
module frz_halt_ctrl
   import frz_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int DEB_CYCLES   = 16,
   parameter int SETTLE_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frz_btn_i,
   input  logic cpu_phi_i,
   input  logic cpu_rw_i,
   input  logic nmi_sense_n_i,
   input  logic rel_stb_i,
   output logic ba_n_o,
   output logic game_n_o,
   output logic exrom_n_o,
   output logic nmi_n_o
);

   localparam int          NSIG     = 4;
   localparam logic [NSIG-1:0] SYNC_RST = 4'b1100; // {nmi, rw, phi, btn}

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("frz_halt_ctrl: SYNC_STAGES must be at least 2");
   end
   if (SETTLE_TICKS < 2) begin : g_bad_settle
      $error("frz_halt_ctrl: SETTLE_TICKS must be at least 2");
   end
   if (DEB_CYCLES < 1) begin : g_bad_deb
      $error("frz_halt_ctrl: DEB_CYCLES must be at least 1");
   end

   logic [NSIG-1:0] raw, synced;
   logic            btn_level, btn_rise;
   logic            tick, tick_rd;
   frz_lines_t      lines;

   assign raw = {nmi_sense_n_i, cpu_rw_i, cpu_phi_i, frz_btn_i};

   frz_sync #(
      .WIDTH  (NSIG),
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST)
   ) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (raw),
      .q_o  (synced)
   );

   frz_debounce #(
      .CYCLES(DEB_CYCLES)
   ) i_deb (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (synced[0]),
      .level_o(btn_level),
      .rise_o (btn_rise)
   );

   frz_cycle_tick i_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .phi_i    (synced[1]),
      .rw_i     (synced[2]),
      .tick_o   (tick),
      .tick_rd_o(tick_rd)
   );

   frz_seq #(
      .SETTLE_TICKS(SETTLE_TICKS)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .press_i   (btn_rise & btn_level),
      .nmi_high_i(synced[3]),
      .tick_i    (tick),
      .tick_rd_i (tick_rd),
      .release_i (rel_stb_i),
      .lines_o   (lines)
   );

   assign ba_n_o    = lines.ba_n;
   assign game_n_o  = lines.game_n;
   assign exrom_n_o = lines.exrom_n;
   assign nmi_n_o   = lines.nmi_n;

endmodule

// File: rtl/frz_halt_ctrl_chk.sv
module frz_halt_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic rel_stb_i,
   input logic ba_n_o,
   input logic game_n_o,
   input logic nmi_n_o
);

   a_r3_ba_drops_alone: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ba_n_o) |-> (game_n_o && nmi_n_o));

   a_r4_map_under_halt: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(game_n_o) |-> (!ba_n_o && nmi_n_o));

   a_r5_nmi_after_map: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nmi_n_o) |-> (!ba_n_o && !game_n_o));

   a_r6_ba_release_last: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ba_n_o) |-> (!nmi_n_o && !game_n_o));

   a_r7_restore_together: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(game_n_o) |-> ($rose(nmi_n_o) && ba_n_o));

   a_r7_restore_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_n_o) |-> $past(rel_stb_i));

endmodule

bind frz_halt_ctrl frz_halt_ctrl_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rel_stb_i(rel_stb_i),
   .ba_n_o   (ba_n_o),
   .game_n_o (game_n_o),
   .nmi_n_o  (nmi_n_o)
);

// File: tb/test_frz_halt_ctrl.sv
module test_frz_halt_ctrl;

   localparam int SYNC   = 2;
   localparam int DEB    = 6;
   localparam int SETTLE = 2;

   typedef enum int {S_IDLE, S_HALT, S_MAP, S_ARM, S_RUN} ref_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic btn = 1'b0, phi = 1'b0, rw = 1'b1, nmi_sense_n = 1'b1, rel_stb = 1'b0;
   logic ba_n, game_n, exrom_n, nmi_n;

   int    checks = 0, fails = 0;
   bit    done = 1'b0;
   ref_t  rs = S_IDLE;
   int    rcnt = 0;
   bit    pend = 1'b0;
   string focus = "";

   always #2 clk = ~clk;

   frz_halt_ctrl #(
      .SYNC_STAGES (SYNC),
      .DEB_CYCLES  (DEB),
      .SETTLE_TICKS(SETTLE)
   ) i_frz_halt_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .frz_btn_i    (btn),
      .cpu_phi_i    (phi),
      .cpu_rw_i     (rw),
      .nmi_sense_n_i(nmi_sense_n),
      .rel_stb_i    (rel_stb),
      .ba_n_o       (ba_n),
      .game_n_o     (game_n),
      .exrom_n_o    (exrom_n),
      .nmi_n_o      (nmi_n)
   );

   // expected {ba_n, game_n, nmi_n}
   function automatic logic [2:0] exp_lines(ref_t s);
      case (s)
         S_HALT:  return 3'b011;
         S_MAP:   return 3'b001;
         S_ARM:   return 3'b000;
         S_RUN:   return 3'b100;
         default: return 3'b111;
      endcase
   endfunction

   function automatic string req_of(ref_t s);
      case (s)
         S_HALT:  return "R3";
         S_MAP:   return "R4";
         S_ARM:   return "R5";
         S_RUN:   return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check_now();
      logic [2:0] act, exp;
      act = {ba_n, game_n, nmi_n};
      exp = exp_lines(rs);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s {ba,game,nmi} actual=%b expected=%b t=%0t",
                  req_of(rs), focus, act, exp, $time);
      end
      checks++;
      if (exrom_n !== 1'b1) begin
         fails++;
         $display("FAIL R10 exrom actual=%b expected=1 t=%0t", exrom_n, $time);
      end
   endtask

   task automatic ref_tick(logic rd);
      case (rs)
         S_HALT: begin
            if (!rd) rcnt = 0;
            else begin
               rcnt++;
               if (rcnt == SETTLE) rs = S_MAP;
            end
         end
         S_MAP:   rs = S_ARM;
         S_ARM:   rs = S_RUN;
         default: ;
      endcase
   endtask

   // cmd: 0 none, 1 press at phase edge, 2 short glitch, 3 let go of button
   task automatic cpu_cycle(logic rd, int cmd, bit rel);
      @(negedge clk);
      phi = 1'b0;
      rw  = rd;
      if (pend) begin
         if (rs == S_IDLE && nmi_sense_n) begin
            rs   = S_HALT;
            rcnt = 0;
         end
         pend = 1'b0;
      end
      if (cmd == 3) btn = 1'b0;
      if (rel) begin
         rel_stb = 1'b1;
         if (rs == S_RUN) rs = S_IDLE;
      end
      @(negedge clk);
      rel_stb = 1'b0;
      repeat (6) @(negedge clk);
      @(negedge clk);
      phi = 1'b1;
      ref_tick(rd);
      if (cmd == 1) begin
         if (!btn) pend = 1'b1;
         btn = 1'b1;
      end
      if (cmd == 2) btn = 1'b1;
      repeat (3) @(negedge clk);
      if (cmd == 2) btn = 1'b0;
      repeat (3) @(negedge clk);
      check_now();
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0000_5eed));
      // R1: reset state
      focus = "R1 reset";
      repeat (3) @(negedge clk);
      check_now();
      @(negedge clk);
      rst_n = 1'b1;
      cpu_cycle(1'b1, 0, 1'b0);
      cpu_cycle(1'b1, 0, 1'b0);

      // R2/R3..R6: full freeze with only reads
      focus = "R2 held press, all reads";
      cpu_cycle(1'b1, 1, 1'b0);
      for (int i = 0; i < 6; i++) cpu_cycle(1'b1, 0, 1'b0);
      cpu_cycle(1'b1, 3, 1'b0);
      focus = "R7 release";
      cpu_cycle(1'b1, 0, 1'b1);
      cpu_cycle(1'b1, 0, 1'b0);

      // R3: writes restart the settle count
      focus = "R3 write restarts wait";
      cpu_cycle(1'b1, 1, 1'b0);
      cpu_cycle(1'b0, 0, 1'b0);
      cpu_cycle(1'b1, 0, 1'b0);
      cpu_cycle(1'b0, 3, 1'b0);
      cpu_cycle(1'b0, 0, 1'b0);
      focus = "R7 strobe in halt ignored";
      cpu_cycle(1'b1, 0, 1'b1);
      focus = "R4 map after reads";
      for (int i = 0; i < 4; i++) cpu_cycle(1'b1, 0, 1'b0);

      // R8: press during active sequence, button held through release
      focus = "R8 press while active";
      cpu_cycle(1'b1, 1, 1'b0);
      cpu_cycle(1'b1, 0, 1'b0);
      cpu_cycle(1'b1, 0, 1'b1);
      focus = "R8 held button no restart";
      for (int i = 0; i < 3; i++) cpu_cycle(1'b1, 0, 1'b0);
      cpu_cycle(1'b1, 3, 1'b0);
      cpu_cycle(1'b1, 0, 1'b0);

      // R2: short glitch rejected
      focus = "R2 glitch rejected";
      cpu_cycle(1'b1, 2, 1'b0);
      for (int i = 0; i < 3; i++) cpu_cycle(1'b1, 0, 1'b0);

      // R9: NMI already low
      focus = "R9 nmi already low";
      nmi_sense_n = 1'b0;
      cpu_cycle(1'b1, 0, 1'b0);
      cpu_cycle(1'b1, 1, 1'b0);
      for (int i = 0; i < 3; i++) cpu_cycle(1'b1, 0, 1'b0);
      cpu_cycle(1'b1, 3, 1'b0);
      nmi_sense_n = 1'b1;
      cpu_cycle(1'b1, 0, 1'b0);

      // random traffic
      focus = "random";
      begin
         bit last_press;
         last_press = 1'b0;
         for (int i = 0; i < 300; i++) begin
            logic rd;
            int   cmd;
            bit   rel;
            rd  = (($urandom % 3) != 0);
            cmd = 0;
            rel = 1'b0;
            if (btn) begin
               if (($urandom % 3) == 0) cmd = 3;
            end else if (($urandom % 4) == 0) cmd = 1;
            else if (($urandom % 10) == 0) cmd = 2;
            if (rs == S_RUN && !last_press && (($urandom % 2) == 0)) rel = 1'b1;
            cpu_cycle(rd, cmd, rel);
            last_press = (cmd == 1);
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule